// File: doc/BRIEF.md
# Vector Mantissa Normalizer with Lane Masking

This block applies a single-precision mantissa normalizer to every 32-bit lane of a vector that is 128, 256 or 512 bits wide. Each lane takes the magnitude of its input, brings the significand into a chosen interval (with k forced to 0 or -1), and sets the sign of the result according to a sign-control field. Special inputs (zeros, infinities, NaNs, subnormals, negatives under a strict sign policy) have fixed results and raise invalid or denormal flags.

Around the lanes sits the vector wrapper. A per-lane write mask (which can be turned off), a choice between merging and zeroing for lanes that are masked off, and a broadcast option that feeds source element 0 to every lane decide what reaches the 512-bit destination. Bits above the selected vector length are always cleared. Exception flags from the lanes that compute are ORed together. Destination and flags are registered, so they appear one clock after the inputs.

Top module: `vmant_apply`

## Requirements
- R1: `vl_sel_i` selects the active lane count: code 0 gives 4 lanes, code 1 gives 8, and codes 2 and 3 give 16.
- R2: Destination bits from the active vector length up to bit 511 are always zero.
- R3: An active lane whose `mask_i` bit is set, or any active lane when `mask_en_i` is 0, receives the normalizer result.
- R4: An active lane that is masked off is written with zero when `zero_i` is 1.
- R5: An active lane that is masked off keeps its `old_dst_i` value when `zero_i` is 0.
- R6: When `bcast_i` is 1, every computing lane uses source bits [31:0] as its input.
- R7: `flags_o` is the OR over computing lanes only. Bit 0 is invalid and bit 1 is denormal. Lanes that are masked off or inactive contribute nothing.
- R8: For a finite nonzero input with no special rule, the fraction field is kept. The sign is 0 if `ctrl_i[2]` is set and the input sign otherwise. The exponent field depends on `ctrl_i[1:0]`: 0 gives 127; 1 gives 126 when the unbiased exponent is odd and 127 otherwise; 2 gives 126; 3 gives 126 when the top fraction bit is set and 127 otherwise.
- R9: With `daz_i` at 0, a subnormal input is first normalized (the fraction is shifted until its leading one becomes implicit, and the unbiased exponent drops by one per shift) and then raises the denormal flag. With `daz_i` at 1, a subnormal input is treated as zero.
- R10: A positive zero or a positive infinity gives 0x3F800000. A negative zero gives +1.0 if `ctrl_i[2]` is set and -1.0 (0xBF800000) otherwise. A negative infinity gives the same result unless `ctrl_i[3]` is set.
- R11: A NaN input is returned with fraction bit 22 set. The invalid flag is raised only when that bit was clear on input.
- R12: A negative input (infinity, or finite and nonzero) with `ctrl_i[3]` set gives 0xFFC00000 and raises the invalid flag.
- R13: Outputs are registered with one cycle of latency, and reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 512 | Source vector, lane i at bits [32i+31:32i] |
| old_dst_i | input | 512 | Previous destination value used for merging |
| mask_i | input | 16 | Per-lane write mask |
| mask_en_i | input | 1 | 1 applies mask_i; 0 treats every lane as selected |
| vl_sel_i | input | 2 | Vector length code |
| bcast_i | input | 1 | Feed source element 0 to every lane |
| zero_i | input | 1 | 1 zeroes masked-off lanes; 0 merges them |
| ctrl_i | input | 8 | [1:0] interval select, [3:2] sign control; upper bits unused |
| daz_i | input | 1 | Treat subnormal inputs as zero |
| dst_o | output | 512 | Registered new destination |
| flags_o | output | 2 | Registered flags: bit 0 invalid, bit 1 denormal |

## Verification
The hardest case to reach is a lane that is masked off but holds an input that would raise a flag, such as a signaling NaN or a subnormal, while the lanes next to it are computing. If the design leaks that lane's flag into `flags_o`, only this case shows it. The masking sweep drives vectors full of special values together with sparse and irregular masks, at every length code and with and without broadcast. Each lane's expected result is computed arithmetically for every combination. A separate sweep runs every interval and sign-control code, with DAZ both off and on, over a fixed set of special values and over random vectors with a forced-subnormal variant.

// File: rtl/vmant_pkg.sv
package vmant_pkg;
  localparam int EW = 32;
  localparam int FW = 23;
  localparam logic [EW-1:0] FP_POS_ONE = 32'h3F80_0000;
  localparam logic [EW-1:0] FP_NEG_ONE = 32'hBF80_0000;
  localparam logic [EW-1:0] FP_QNAN_DF = 32'hFFC0_0000;

  typedef struct packed {
    logic den;
    logic inv;
  } exc_t;

  // position of the leading one counted from bit FW-1; FW when zero
  function automatic logic [4:0] lead_zeros(input logic [FW-1:0] f);
    logic [4:0] n;
    n = 5'(FW);
    for (int b = 0; b < FW; b++) begin
      if (f[b]) n = 5'(FW - 1 - b);
    end
    return n;
  endfunction
endpackage

// File: rtl/mant_lane.sv
module mant_lane
  import vmant_pkg::*;
(
  input  logic [EW-1:0] val_i,
  input  logic [1:0]    intv_i,
  input  logic [1:0]    sgn_i,
  input  logic          daz_i,
  output logic [EW-1:0] res_o,
  output exc_t          exc_o
);
  logic          s_in;
  logic [7:0]    e_in;
  logic [FW-1:0] f_in;
  logic          is_nan, is_inf, is_zero, is_den;
  logic [4:0]    lz;
  logic [5:0]    shamt;
  logic [FW-1:0] f_nrm;
  logic [7:0]    e_nrm;
  logic [7:0]    e_out;
  logic          odd_k;

  always_comb begin
    s_in    = val_i[EW-1];
    e_in    = val_i[EW-2:FW];
    f_in    = val_i[FW-1:0];
    is_nan  = (e_in == 8'hFF) && (f_in != '0);
    is_inf  = (e_in == 8'hFF) && (f_in == '0);
    is_zero = (e_in == 8'h00) && ((f_in == '0) || daz_i);
    is_den  = (e_in == 8'h00) && (f_in != '0) && !daz_i;
    lz      = lead_zeros(f_in);
    shamt   = 6'(lz) + 6'd1;
    f_nrm   = is_den ? FW'(f_in << shamt) : f_in;
    e_nrm   = is_den ? (8'd126 - 8'(lz)) : e_in;
    odd_k   = ~e_nrm[0];
    case (intv_i)
      2'd0:    e_out = 8'd127;
      2'd1:    e_out = odd_k ? 8'd126 : 8'd127;
      2'd2:    e_out = 8'd126;
      default: e_out = f_nrm[FW-1] ? 8'd126 : 8'd127;
    endcase
  end

  always_comb begin
    res_o     = {(sgn_i[0] ? 1'b0 : s_in), e_out, f_nrm};
    exc_o.inv = 1'b0;
    exc_o.den = is_den;
    if (is_nan) begin
      res_o     = val_i | (EW'(1) << (FW - 1));
      exc_o.inv = ~f_in[FW-1];
      exc_o.den = 1'b0;
    end else if (is_zero || is_inf) begin
      exc_o.den = 1'b0;
      if (!s_in) begin
        res_o = FP_POS_ONE;
      end else if (is_inf && sgn_i[1]) begin
        res_o     = FP_QNAN_DF;
        exc_o.inv = 1'b1;
      end else begin
        res_o = sgn_i[0] ? FP_POS_ONE : FP_NEG_ONE;
      end
    end else if (s_in && sgn_i[1]) begin
      res_o     = FP_QNAN_DF;
      exc_o.inv = 1'b1;
      exc_o.den = 1'b0;
    end
  end

  always_comb begin
    if (exc_o.inv) begin
      // R11 R12
      inv_gives_qnan_chk: assert (res_o[EW-2:FW] == 8'hFF && res_o[FW-1]);
    end
    if (exc_o.den) begin
      // R9
      den_interval_chk: assert (res_o[EW-2:FW] == 8'd126 || res_o[EW-2:FW] == 8'd127);
    end
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import vmant_pkg::*;
(
  input  logic [EW-1:0] res_i,
  input  logic [EW-1:0] old_i,
  input  logic          act_i,
  input  logic          sel_i,
  input  logic          zero_i,
  output logic [EW-1:0] out_o
);
  always_comb begin
    if (!act_i)      out_o = '0;
    else if (sel_i)  out_o = res_i;
    else if (zero_i) out_o = '0;
    else             out_o = old_i;
  end
endmodule

// File: rtl/vmant_apply.sv
module vmant_apply
  import vmant_pkg::*;
#(
  parameter int MAX_LANES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MAX_LANES*32-1:0] src_i,
  input  logic [MAX_LANES*32-1:0] old_dst_i,
  input  logic [MAX_LANES-1:0]    mask_i,
  input  logic                    mask_en_i,
  input  logic [1:0]              vl_sel_i,
  input  logic                    bcast_i,
  input  logic                    zero_i,
  input  logic [7:0]              ctrl_i,
  input  logic                    daz_i,
  output logic [MAX_LANES*32-1:0] dst_o,
  output logic [1:0]              flags_o
);
  localparam int VW = MAX_LANES * EW;
  localparam int CW = $clog2(MAX_LANES + 1);

  logic [CW-1:0]        n_lanes;
  logic [VW-1:0]        dst_d;
  exc_t                 lane_exc [MAX_LANES];
  exc_t                 flags_d;

  always_comb begin
    case (vl_sel_i)
      2'd0:    n_lanes = CW'(MAX_LANES / 4);
      2'd1:    n_lanes = CW'(MAX_LANES / 2);
      default: n_lanes = CW'(MAX_LANES);
    endcase
  end

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    logic [EW-1:0] lane_in;
    logic [EW-1:0] lane_res;
    exc_t          lane_raw;
    logic          act;
    logic          sel;

    assign lane_in = bcast_i ? src_i[EW-1:0] : src_i[g*EW +: EW];
    assign act     = (CW'(g) < n_lanes);
    assign sel     = act && (!mask_en_i || mask_i[g]);

    mant_lane u_lane (
      .val_i  (lane_in),
      .intv_i (ctrl_i[1:0]),
      .sgn_i  (ctrl_i[3:2]),
      .daz_i  (daz_i),
      .res_o  (lane_res),
      .exc_o  (lane_raw)
    );

    lane_merge u_merge (
      .res_i  (lane_res),
      .old_i  (old_dst_i[g*EW +: EW]),
      .act_i  (act),
      .sel_i  (sel),
      .zero_i (zero_i),
      .out_o  (dst_d[g*EW +: EW])
    );

    assign lane_exc[g] = sel ? lane_raw : exc_t'('0);
  end

  always_comb begin
    flags_d = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      flags_d = flags_d | lane_exc[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_o   <= '0;
      flags_o <= '0;
    end else begin
      dst_o   <= dst_d;
      flags_o <= flags_d;
    end
  end

  // R2
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vl_sel_i) == 2'd0) |-> (dst_o[VW-1:VW/4] == '0));

  // R4
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_i && mask_en_i && (mask_i == '0)) |-> (dst_o == '0));

  // R5
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!zero_i && mask_en_i && (mask_i == '0) && vl_sel_i[1])
      |-> (dst_o == $past(old_dst_i)));

  // R6
  bcast_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bcast_i && !mask_en_i && (vl_sel_i != 2'd0))
      |-> (dst_o[2*EW-1:EW] == dst_o[EW-1:0]));

  // R7
  no_masked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_en_i && (mask_i == '0)) |-> (flags_o == 2'b00));
endmodule

// File: tb/sim_vmant_apply.sv
`timescale 1ns/1ps
module sim_vmant_apply;
  localparam int L = 16;
  localparam int VW = L * 32;

  logic          clk;
  logic          rst_n;
  logic [VW-1:0] src_i, old_dst_i;
  logic [L-1:0]  mask_i;
  logic          mask_en_i, bcast_i, zero_i, daz_i;
  logic [1:0]    vl_sel_i;
  logic [7:0]    ctrl_i;
  logic [VW-1:0] dst_o;
  logic [1:0]    flags_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] rng = 32'h1234_5678;

  vmant_apply u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .old_dst_i(old_dst_i),
    .mask_i(mask_i), .mask_en_i(mask_en_i), .vl_sel_i(vl_sel_i),
    .bcast_i(bcast_i), .zero_i(zero_i), .ctrl_i(ctrl_i), .daz_i(daz_i),
    .dst_o(dst_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] nextr(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // returns {den, inv, result}
  function automatic logic [33:0] ref_lane(input logic [31:0] x, input logic [3:0] c, input logic daz);
    logic        s;
    logic [7:0]  e;
    logic [22:0] f;
    logic [23:0] sig;
    int          k;
    logic [7:0]  eo;
    logic        den;
    s = x[31]; e = x[30:23]; f = x[22:0];
    if (e == 8'hFF && f != 0) return {1'b0, ~f[22], x | 32'h0040_0000};
    if ((e == 0 && (f == 0 || daz)) || e == 8'hFF) begin
      if (!s) return {2'b00, 32'h3F80_0000};
      if (e == 8'hFF && c[3]) return {2'b01, 32'hFFC0_0000};
      return {2'b00, c[2] ? 32'h3F80_0000 : 32'hBF80_0000};
    end
    if (s && c[3]) return {2'b01, 32'hFFC0_0000};
    den = 1'b0;
    if (e == 0) begin
      sig = {1'b0, f}; k = -126; den = 1'b1;
      while (!sig[23]) begin sig = sig << 1; k = k - 1; end
    end else begin
      sig = {1'b1, f}; k = int'(e) - 127;
    end
    case (c[1:0])
      2'd0: eo = 8'd127;
      2'd1: eo = (k % 2 != 0) ? 8'd126 : 8'd127;
      2'd2: eo = 8'd126;
      default: eo = sig[22] ? 8'd126 : 8'd127;
    endcase
    return {den, 1'b0, (c[2] ? 1'b0 : s), eo, sig[22:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] x, input logic [3:0] c, input logic daz);
    if (x[30:23] == 8'hFF && x[22:0] != 0) return "R11";
    if (x[31] && c[3] && !(x[30:23] == 0 && (x[22:0] == 0 || daz))) return "R12";
    if (x[30:23] == 8'hFF || (x[30:23] == 0 && (x[22:0] == 0 || daz))) return "R10";
    if (x[30:23] == 0) return "R9";
    return "R8";
  endfunction

  task automatic chk(input string tag, input int lane, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s lane %0d: got %h expected %h", tag, lane, got, exp);
    end
  endtask

  // apply current inputs, wait for the register, compare every lane and the flags
  task automatic run_step();
    logic [1:0]  fexp;
    logic [33:0] r;
    logic [31:0] lin, e;
    int          nl;
    bit          sel;
    string       t;
    @(negedge clk);
    nl = (vl_sel_i == 0) ? 4 : (vl_sel_i == 1) ? 8 : 16;
    fexp = 2'b00;
    for (int i = 0; i < L; i++) begin
      lin = bcast_i ? src_i[31:0] : src_i[i*32 +: 32];
      sel = (i < nl) && (!mask_en_i || mask_i[i]);
      r = ref_lane(lin, ctrl_i[3:0], daz_i);
      if (i >= nl)        begin e = 32'h0; t = "R1/R2"; end
      else if (sel)       begin e = r[31:0]; fexp = fexp | r[33:32];
                                t = bcast_i ? "R6" : (mask_en_i ? "R3" : tag_of(lin, ctrl_i[3:0], daz_i)); end
      else if (zero_i)    begin e = 32'h0; t = "R4"; end
      else                begin e = old_dst_i[i*32 +: 32]; t = "R5"; end
      chk(t, i, dst_o[i*32 +: 32], e);
    end
    chk("R7", -1, {30'h0, flags_o}, {30'h0, fexp});
  endtask

  function automatic logic [31:0] special(input int n);
    case (n % 16)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h7F80_0000;  3: return 32'hFF80_0000;
      4: return 32'h7FC0_0001;  5: return 32'h7F80_0001;
      6: return 32'hFF80_0005;  7: return 32'h0000_0001;
      8: return 32'h8040_0000;  9: return 32'h007F_FFFF;
      10: return 32'h3F80_0000; 11: return 32'h4049_0FDB;
      12: return 32'hC000_0000; 13: return 32'h3FC0_0000;
      14: return 32'h4120_0000; default: return 32'h7F7F_FFFF;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_i = '0; old_dst_i = '0; mask_i = '0; mask_en_i = 1'b0;
    vl_sel_i = 2'd2; bcast_i = 1'b0; zero_i = 1'b0; ctrl_i = '0; daz_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13", -1, dst_o[31:0] | dst_o[VW-1:VW-32], 32'h0);
    chk("R13", -1, {30'h0, flags_o}, 32'h0);
    rst_n = 1'b1;

    // function sweep: every interval/sign code, DAZ both ways, several vectors
    for (int set = 0; set < 5; set++) begin
      for (int i = 0; i < L; i++) begin
        rng = nextr(rng);
        if (set == 0)      src_i[i*32 +: 32] = special(i);
        else if (set == 2) src_i[i*32 +: 32] = rng & 32'h807F_FFFF;
        else               src_i[i*32 +: 32] = rng;
      end
      for (int c = 0; c < 16; c++) begin
        for (int d = 0; d < 2; d++) begin
          ctrl_i = 8'(c); daz_i = d[0];
          run_step();
        end
      end
    end

    // masking sweep: length, mask enable, zeroing, broadcast, several masks
    for (int v = 0; v < 4; v++)
      for (int me = 0; me < 2; me++)
        for (int z = 0; z < 2; z++)
          for (int b = 0; b < 2; b++)
            for (int m = 0; m < 4; m++) begin
              rng = nextr(rng);
              vl_sel_i = 2'(v); mask_en_i = me[0]; zero_i = z[0]; bcast_i = b[0];
              mask_i = (m == 0) ? 16'h0000 : (m == 1) ? 16'hFFFF : (m == 2) ? 16'hA5C3 : rng[15:0];
              ctrl_i = {4'h0, rng[19:16]}; daz_i = rng[20];
              for (int i = 0; i < L; i++) begin
                rng = nextr(rng);
                src_i[i*32 +: 32] = rng[0] ? special(int'(rng[8:5]) + i) : rng;
                old_dst_i[i*32 +: 32] = nextr(rng);
              end
              if (m == 2) src_i[63:32] = 32'h7F80_0001;
              run_step();
            end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule